// File: doc/BRIEF.md
# Prescaled Elapsed-Time Timer

This block is a free-running timer peripheral behind a word-addressed register port. A prescaler divides the system clock into time units, and a main counter counts those units. Software programs a prescale value and a target count, then starts the timer by writing a command bit. The timer runs until software sends a stop command.

Once the elapsed time equals the target, the timer raises a sticky flag and keeps counting. Command bits are one-cycle strobes and are not stored. While the timer runs, it refuses new prescale and target values. Reads are combinational.

Software must program both the prescale value and the target with non-zero values. Zero values are not a supported setting.

Top module: `tick_timer`

## Requirements
- R1: After reset, the prescale register (word 0x0a) reads 1, the target register (word 0x0b) reads 1, and the status word (0x09) reads 0.
- R2: A write to word 0x08 with bit 0 set and bit 1 clear, while the timer is stopped, sets status bit 0 (running), clears status bit 1 (reached) and zeroes both internal counters.
- R3: A write to word 0x08 with bit 1 set clears the running bit. If bits 0 and 1 are written together, the stop command wins.
- R4: With prescale P and target T, the reached bit is 0 up to clock edge P*T-1 after the start edge and is 1 at edge P*T.
- R5: The reached bit stays set while the timer keeps running past the target. A stop command leaves the reached bit set.
- R6: Writes to words 0x0a and 0x0b are ignored while the timer is running.
- R7: Reading word 0x0b while the timer runs returns the elapsed unit count, which is floor(k/P) after k edges. Reading it while the timer is stopped returns the programmed target.
- R8: A start command received while the timer is running is ignored. The counters keep advancing.
- R9: Reads of unmapped words, and reads with chip-select low, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| we | input | 1 | Write enable; a read when low |
| addr | input | 8 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data |

## Verification
The bench targets the exact cycle at which the reached bit rises, for several prescale and target pairs, including the single-cycle case 1×1. A design with an off-by-one prescaler wrap would raise the flag a cycle early or late.

Other corner cases each have a directed check:
- A start sent while the timer is running. A design that accepts it would restart the count, and the elapsed value read back would come out low.
- Writing start and stop together. A design without stop priority would leave the timer running.
- Configuration writes made during a run. A design that accepts them would read back the new values after the stop.
- Re-reading the reached bit after a stop and after a new start. This exposes a flag that is either not sticky or never cleared.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] WORD_CMD    = 8'h08;
  localparam logic [ADDR_W-1:0] WORD_STATE  = 8'h09;
  localparam logic [ADDR_W-1:0] WORD_PRESC  = 8'h0a;
  localparam logic [ADDR_W-1:0] WORD_TARGET = 8'h0b;

  localparam int CMD_GO_BIT   = 0;
  localparam int CMD_HALT_BIT = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic clearCnt;  // start accepted: zero both counters
    logic countEn;   // timer running: advance counters
    logic cfgLock;   // refuse configuration writes
  } timer_cmd_t;
endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    cmdBits,
  input  logic          targetHit,
  output timer_cmd_t    cmd,
  output logic          running,
  output logic          reached
);
  logic cmdWrite;
  logic goReq;
  logic haltReq;

  assign cmdWrite = cs && we && (addr == WORD_CMD);
  assign haltReq  = cmdWrite && cmdBits[CMD_HALT_BIT];
  assign goReq    = cmdWrite && cmdBits[CMD_GO_BIT] && !cmdBits[CMD_HALT_BIT] && !running;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      reached <= 1'b0;
    end else begin
      if (haltReq)    running <= 1'b0;
      else if (goReq) running <= 1'b1;

      if (goReq)          reached <= 1'b0;
      else if (targetHit) reached <= 1'b1;
    end
  end

  always_comb begin
    cmd.clearCnt = goReq;
    cmd.countEn  = running;
    cmd.cfgLock  = running;
  end
endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  input  timer_cmd_t    cmd,
  output logic [DW-1:0] prescVal,
  output logic [DW-1:0] targetVal,
  output logic [DW-1:0] unitCnt,
  output logic          targetHit
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] prescCnt;
  logic          unitTick;
  logic          prescWr;
  logic          targetWr;

  assign prescWr   = cs && we && (addr == WORD_PRESC)  && !cmd.cfgLock;
  assign targetWr  = cs && we && (addr == WORD_TARGET) && !cmd.cfgLock;
  assign unitTick  = cmd.countEn && (prescCnt == prescVal - ONE);
  assign targetHit = unitTick && ((unitCnt + ONE) == targetVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescVal  <= ONE;
      targetVal <= ONE;
    end else begin
      if (prescWr)  prescVal  <= wrData;
      if (targetWr) targetVal <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescCnt <= '0;
      unitCnt  <= '0;
    end else if (cmd.clearCnt) begin
      prescCnt <= '0;
      unitCnt  <= '0;
    end else if (cmd.countEn) begin
      if (unitTick) begin
        prescCnt <= '0;
        unitCnt  <= unitCnt + ONE;
      end else begin
        prescCnt <= prescCnt + ONE;
      end
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);
  timer_cmd_t    cmd;
  logic          running;
  logic          reached;
  logic          targetHit;
  logic [DW-1:0] prescVal;
  logic [DW-1:0] targetVal;
  logic [DW-1:0] unitCnt;

  tick_timer_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cs(cs), .we(we), .addr(addr),
    .cmdBits(wrData[1:0]), .targetHit(targetHit),
    .cmd(cmd), .running(running), .reached(reached)
  );

  tick_timer_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .cs(cs), .we(we), .addr(addr),
    .wrData(wrData), .cmd(cmd), .prescVal(prescVal),
    .targetVal(targetVal), .unitCnt(unitCnt), .targetHit(targetHit)
  );

  always_comb begin
    rdData = '0;
    if (cs && !we) begin
      unique case (addr)
        WORD_STATE:  rdData = {{(DW-2){1'b0}}, reached, running};
        WORD_PRESC:  rdData = prescVal;
        WORD_TARGET: rdData = running ? unitCnt : targetVal;
        default:     rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input logic          clk,
  input logic          rstN,
  input logic          cs,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wrData,
  input logic          running,
  input logic          reached,
  input logic [DW-1:0] prescVal,
  input logic [DW-1:0] targetVal
);
  logic cmdWr;
  assign cmdWr = cs && we && (addr == WORD_CMD);

  assert_stop_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && wrData[CMD_HALT_BIT]) |=> !running);

  assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && wrData[CMD_GO_BIT] && !wrData[CMD_HALT_BIT] && !running) |=> (running && !reached));

  assert_cfg_locked_R6: assert property (@(posedge clk) disable iff (!rstN)
    running |=> ($stable(prescVal) && $stable(targetVal)));

  assert_reached_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reached && running) |=> reached);

  assert_restart_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (running && !(cmdWr && wrData[CMD_HALT_BIT])) |=> running);

  assert_reach_while_running_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reached) |-> $past(running));
endmodule

bind tick_timer tick_timer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .cs(cs), .we(we), .addr(addr), .wrData(wrData),
  .running(running), .reached(reached), .prescVal(prescVal), .targetVal(targetVal)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cs = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  int nRun = 0;
  int nFail = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  tick_timer u0 (.clk(clk), .rstN(rstN), .cs(cs), .we(we), .addr(addr),
                 .wrData(wrData), .rdData(rdData));

  // {prescale, target}
  localparam logic [63:0] VEC [5] = '{
    {32'd1, 32'd1}, {32'd1, 32'd6}, {32'd3, 32'd4}, {32'd5, 32'd3}, {32'd2, 32'd7}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    #2;
    cs = 1'b0; we = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    cs = 1'b1; we = 1'b0; addr = a;
    #1;
    d = rdData;
    cs = 1'b0;
    #1;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  initial begin
    #200000;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R1 reset values
    rd(8'h0a, rv); check("R1 prescale reset", rv, 32'd1);
    rd(8'h0b, rv); check("R1 target reset", rv, 32'd1);
    rd(8'h09, rv); check("R1 status reset", rv, 32'd0);
    // R9 unmapped and deselected reads
    rd(8'h00, rv); check("R9 unmapped 0x00", rv, 32'd0);
    rd(8'h0c, rv); check("R9 unmapped 0x0c", rv, 32'd0);
    cs = 1'b0; addr = 8'h0a; #1; check("R9 cs low", rdData, 32'd0); #1;

    // vector table walk
    for (int v = 0; v < 5; v++) begin
      int p, t, n;
      p = int'(VEC[v][63:32]);
      t = int'(VEC[v][31:0]);
      n = p * t;
      wr(8'h0a, VEC[v][63:32]);
      wr(8'h0b, VEC[v][31:0]);
      wr(8'h08, 32'h1);
      rd(8'h09, rv); check("R2 started, reached clear", rv, 32'h1);
      edges(n - 1);
      rd(8'h09, rv); check("R4 not yet reached", rv, 32'h1);
      rd(8'h0b, rv); check("R7 elapsed count", rv, 32'((n - 1) / p));
      edges(1);
      rd(8'h09, rv); check("R4 reached on time", rv, 32'h3);
      edges(5);
      rd(8'h09, rv); check("R5 runs past target", rv, 32'h3);
      wr(8'h08, 32'h2);
      rd(8'h09, rv); check("R5 stop keeps reached", rv, 32'h2);
      rd(8'h0b, rv); check("R7 stopped reads target", rv, VEC[v][31:0]);
    end

    // R2: new start clears reached
    wr(8'h08, 32'h1);
    rd(8'h09, rv); check("R2 restart clears reached", rv, 32'h1);
    wr(8'h08, 32'h2);

    // R6 lock and R8 start-while-running
    wr(8'h0a, 32'd2);
    wr(8'h0b, 32'd100);
    wr(8'h08, 32'h1);
    edges(10);
    rd(8'h0b, rv); check("R7 running count", rv, 32'd5);
    wr(8'h08, 32'h1);
    edges(9);
    rd(8'h0b, rv); check("R8 start ignored while running", rv, 32'd10);
    wr(8'h0a, 32'd9);
    wr(8'h0b, 32'd55);
    wr(8'h08, 32'h3);
    rd(8'h09, rv); check("R3 both bits stop while running", rv, 32'h0);
    rd(8'h0a, rv); check("R6 prescale locked", rv, 32'd2);
    rd(8'h0b, rv); check("R6 target locked", rv, 32'd100);

    // R3 stop wins while stopped
    wr(8'h08, 32'h3);
    rd(8'h09, rv); check("R3 stop wins over start", rv, 32'h0);
    // R6 writes accepted when stopped
    wr(8'h0a, 32'd4);
    rd(8'h0a, rv); check("R6 write when stopped", rv, 32'd4);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule